// File: doc/BRIEF.md
# Channel Command Fetch Sequencer

This block fetches the first word of each channel command for a single I/O subchannel. A start request loads a command pointer from a supplied 32-bit register value and marks the device busy. The block then reads command words from memory over a single-outstanding request/response port and decodes each word's order field. A device order updates the device-side order register, the memory byte address register and the transfer direction flag. A transfer-in-channel (jump) word is handled entirely inside the sequencer: it redirects the command pointer and fetches the next command straight away.

The command pointer holds a doubleword address. Every fetch reads the even word of that doubleword, and the pointer advances by one doubleword per word fetched. A data-chained continuation reloads only the byte address, leaving the device order untouched. A jump followed immediately by another jump is a channel control error. The sequencer then stops fetching and stays halted until a channel reset. A halt input aborts the operation at any point. If a read is in flight when the abort arrives, its late response is absorbed, and no new request is issued before that response returns.

Top module: `chan_cmd_fetch`

## Requirements
- R1: After reset, dev_busy, mem_req_valid, ctl_err, dev_order_load and cmd_loaded are 0, and dev_order, byte_addr and backward are 0.
- R2: A start is accepted only while the sequencer is idle, and dev_busy is 1 from the cycle after acceptance. A start while busy or while in error halt has no effect.
- R3: Each fetch requests word address 2*P, where P is the command pointer (start_addr bits [18:0] on start). P advances by one after every accepted request, so consecutive commands come from word addresses 2P, 2P+2, ...
- R4: For a non-jump word, byte_addr takes word bits [21:0] and dev_order takes word bits [31:24]. One cycle later, cmd_loaded pulses for one cycle and all three outputs show the new values.
- R5: When a command is fetched as a data-chained continuation (next_dchain=1 with next_req), byte_addr is reloaded but dev_order and backward keep their values, and dev_order_load stays 0.
- R6: backward is set to 1 when a loaded device order equals 8'h0C and cleared by any other loaded device order.
- R7: A word with bits [27:24] = 4'b1000 is a jump, whatever bits [31:28] hold. Bits [18:0] replace P, and the next fetch follows at once from word address 2*(bits [18:0]). The jump leaves dev_order, byte_addr and backward unchanged, produces no cmd_loaded or dev_order_load, and keeps the data-chaining state of the command being fetched.
- R8: A jump whose target word is also a jump sets ctl_err, clears dev_busy, and issues no further memory requests. Starts are then ignored until chan_rst.
- R9: At most one memory request is outstanding. halt clears dev_busy and aborts any fetch. A response to an aborted request is discarded and never loaded, and no new request is issued before it arrives.
- R10: chan_rst clears ctl_err, dev_busy, dev_order, byte_addr and backward, and returns the sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, one cycle |
| start_addr | input | 32 | Register value holding the first command doubleword address |
| halt | input | 1 | Abort the current operation |
| chan_rst | input | 1 | Synchronous channel reset, clears error halt |
| next_req | input | 1 | Fetch the next command (chaining) |
| next_dchain | input | 1 | With next_req: the next command continues a data chain |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | CAW+1 | Word address of the read |
| mem_rsp_valid | input | 1 | One-cycle read response strobe |
| mem_rsp_data | input | 32 | Read data |
| dev_busy | output | 1 | Device busy (1) or ready (0) |
| dev_order | output | 8 | Device order register |
| dev_order_load | output | 1 | Pulses when dev_order is written |
| byte_addr | output | BAW | Memory byte address register |
| backward | output | 1 | Byte address counts down during transfer |
| cmd_loaded | output | 1 | Pulses when a device command has been decoded |
| ctl_err | output | 1 | Channel control error (two jumps in a row) |

## Verification
The embedded properties watch several rules on every cycle. They check that at most one read is ever outstanding and that a jump never disturbs the device-side registers. They also check that a data-chained load keeps the order and direction, that no request leaves the block while the error flag is set, and that busy rises only after a start. The order of addresses fetched through chains and jumps cannot be checked by a single-cycle property, so the bench scenarios show it. The same holds for the values loaded from each word, a jump inside a data chain, and a stale response absorbed after a halt while a new start waits behind it.

// File: rtl/chan_fetch_pkg.sv
package chan_fetch_pkg;

   localparam int unsigned CMD_W      = 32;
   localparam int unsigned ORD_W      = 8;
   localparam int unsigned BA_FIELD_W = 22;
   localparam int unsigned JT_FIELD_W = 19;
   localparam logic [3:0]  JUMP_NIBBLE = 4'b1000;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_REQ,
      FS_WAIT,
      FS_LOADED,
      FS_ERRH
   } fetch_state_e;

endpackage

// File: rtl/cmd_word_decode.sv
module cmd_word_decode
   import chan_fetch_pkg::*;
#(
   parameter logic [ORD_W-1:0] RDBACK_CODE     = 8'h0C,
   parameter bit               JUMP_HI_IGNORED = 1'b1
) (
   input  logic [CMD_W-1:0]      word,
   output logic [ORD_W-1:0]      order,
   output logic                  is_jump,
   output logic                  is_rdback,
   output logic [BA_FIELD_W-1:0] ba_field,
   output logic [JT_FIELD_W-1:0] jt_field
);

   localparam int unsigned ORD_LSB = CMD_W - ORD_W;

   assign order    = word[CMD_W-1:ORD_LSB];
   assign ba_field = word[BA_FIELD_W-1:0];
   assign jt_field = word[JT_FIELD_W-1:0];

   generate
      if (JUMP_HI_IGNORED) begin : g_jump_nibble
         assign is_jump = (order[3:0] == JUMP_NIBBLE);
      end else begin : g_jump_full
         assign is_jump = (order == {{(ORD_W-4){1'b0}}, JUMP_NIBBLE});
      end
   endgenerate

   assign is_rdback = !is_jump && (order == RDBACK_CODE);

   logic unused_gap;
   assign unused_gap = ^word[ORD_LSB-1:BA_FIELD_W];

endmodule

// File: rtl/cmd_addr_reg.sv
module cmd_addr_reg #(
   parameter int unsigned CAW = 19
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           ld_start,
   input  logic [CAW-1:0] start_val,
   input  logic           ld_jump,
   input  logic [CAW-1:0] jump_val,
   input  logic           inc,
   output logic [CAW:0]   word_addr
);

   logic [CAW-1:0] cad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cad <= '0;
      end else if (clr) begin
         cad <= '0;
      end else if (ld_start) begin
         cad <= start_val;
      end else if (ld_jump) begin
         cad <= jump_val;
      end else if (inc) begin
         cad <= cad + 1'b1;
      end
   end

   assign word_addr = {cad, 1'b0};

   // R3: one accepted fetch moves the pointer to the next doubleword
   a_r3_advance_one_dw: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && !ld_start && !ld_jump) |=> (word_addr == $past(word_addr) + 2'd2));

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
   import chan_fetch_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic halt,
   input  logic chan_rst,
   input  logic next_req,
   input  logic next_dchain,
   input  logic mem_req_ready,
   input  logic mem_rsp_valid,
   input  logic dec_is_jump,
   output logic mem_req_valid,
   output logic ld_start,
   output logic ld_jump,
   output logic inc,
   output logic ld_cmd,
   output logic ld_order,
   output logic dev_busy,
   output logic ctl_err,
   output logic cmd_loaded,
   output logic order_pulse
);

   fetch_state_e state;
   logic drain;
   logic jump_prev;
   logic dchain;
   logic abort;
   logic hs;
   logic rsp_take;

   assign abort         = halt || chan_rst;
   assign mem_req_valid = (state == FS_REQ) && !drain;
   assign hs            = mem_req_valid && mem_req_ready;
   assign inc           = hs;
   assign ld_start      = (state == FS_IDLE) && start && !abort;
   assign rsp_take      = (state == FS_WAIT) && mem_rsp_valid && !abort;
   assign ld_jump       = rsp_take && dec_is_jump && !jump_prev;
   assign ld_cmd        = rsp_take && !dec_is_jump;
   assign ld_order      = ld_cmd && !dchain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drain <= 1'b0;
      end else if (abort && (hs || ((state == FS_WAIT) && !mem_rsp_valid))) begin
         drain <= 1'b1;
      end else if (drain && mem_rsp_valid) begin
         drain <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_loaded  <= 1'b0;
         order_pulse <= 1'b0;
      end else begin
         cmd_loaded  <= ld_cmd;
         order_pulse <= ld_order;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= FS_IDLE;
         jump_prev <= 1'b0;
         dchain    <= 1'b0;
         ctl_err   <= 1'b0;
         dev_busy  <= 1'b0;
      end else if (chan_rst) begin
         state     <= FS_IDLE;
         jump_prev <= 1'b0;
         dchain    <= 1'b0;
         ctl_err   <= 1'b0;
         dev_busy  <= 1'b0;
      end else if (halt) begin
         if (state != FS_ERRH) begin
            state <= FS_IDLE;
         end
         dev_busy <= 1'b0;
      end else begin
         unique case (state)
            FS_IDLE: begin
               if (start) begin
                  dev_busy  <= 1'b1;
                  jump_prev <= 1'b0;
                  dchain    <= 1'b0;
                  state     <= FS_REQ;
               end
            end
            FS_REQ: begin
               if (hs) begin
                  state <= FS_WAIT;
               end
            end
            FS_WAIT: begin
               if (mem_rsp_valid) begin
                  if (dec_is_jump && jump_prev) begin
                     ctl_err  <= 1'b1;
                     dev_busy <= 1'b0;
                     state    <= FS_ERRH;
                  end else if (dec_is_jump) begin
                     jump_prev <= 1'b1;
                     state     <= FS_REQ;
                  end else begin
                     jump_prev <= 1'b0;
                     state     <= FS_LOADED;
                  end
               end
            end
            FS_LOADED: begin
               if (next_req) begin
                  dchain <= next_dchain;
                  state  <= FS_REQ;
               end
            end
            FS_ERRH: begin
               state <= FS_ERRH;
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   // R2: busy only ever rises after a start request
   a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_busy) |-> $past(start));

   // R8: the error halt persists until a channel reset
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_err && !chan_rst) |=> ctl_err);

   // R10: channel reset clears error and busy
   a_r10_chan_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst |=> (!ctl_err && !dev_busy));

endmodule

// File: rtl/dev_order_regs.sv
module dev_order_regs
   import chan_fetch_pkg::*;
#(
   parameter int unsigned BAW = 22
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  ld_cmd,
   input  logic                  ld_order,
   input  logic [ORD_W-1:0]      order_in,
   input  logic                  rdback_in,
   input  logic [BA_FIELD_W-1:0] ba_in,
   output logic [ORD_W-1:0]      dev_order,
   output logic [BAW-1:0]        byte_addr,
   output logic                  backward
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_order <= '0;
         byte_addr <= '0;
         backward  <= 1'b0;
      end else if (clr) begin
         dev_order <= '0;
         byte_addr <= '0;
         backward  <= 1'b0;
      end else if (ld_cmd) begin
         byte_addr <= ba_in[BAW-1:0];
         if (ld_order) begin
            dev_order <= order_in;
            backward  <= rdback_in;
         end
      end
   end

   // R5: a data-chained load keeps order and direction
   a_r5_chain_keeps_order: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_cmd && !ld_order && !clr) |=> ($stable(dev_order) && $stable(backward)));

endmodule

// File: rtl/chan_cmd_fetch.sv
module chan_cmd_fetch
   import chan_fetch_pkg::*;
#(
   parameter int unsigned      CAW             = 19,
   parameter int unsigned      BAW             = 22,
   parameter logic [7:0]       RDBACK_CODE     = 8'h0C,
   parameter bit               JUMP_HI_IGNORED = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [31:0]    start_addr,
   input  logic           halt,
   input  logic           chan_rst,
   input  logic           next_req,
   input  logic           next_dchain,
   output logic           mem_req_valid,
   input  logic           mem_req_ready,
   output logic [CAW:0]   mem_req_addr,
   input  logic           mem_rsp_valid,
   input  logic [31:0]    mem_rsp_data,
   output logic           dev_busy,
   output logic [7:0]     dev_order,
   output logic           dev_order_load,
   output logic [BAW-1:0] byte_addr,
   output logic           backward,
   output logic           cmd_loaded,
   output logic           ctl_err
);

   initial begin : cfg_check
      a_cfg_caw: assert (CAW >= 1 && CAW <= JT_FIELD_W)
         else $error("CAW must lie in 1..%0d", JT_FIELD_W);
      a_cfg_baw: assert (BAW >= 1 && BAW <= BA_FIELD_W)
         else $error("BAW must lie in 1..%0d", BA_FIELD_W);
   end

   logic [ORD_W-1:0]      dec_order;
   logic                  dec_is_jump;
   logic                  dec_is_rdback;
   logic [BA_FIELD_W-1:0] dec_ba;
   logic [JT_FIELD_W-1:0] dec_jt;
   logic ld_start, ld_jump, inc, ld_cmd, ld_order;

   logic unused_start_hi;
   assign unused_start_hi = ^start_addr[31:CAW];

   cmd_word_decode #(
      .RDBACK_CODE     (RDBACK_CODE),
      .JUMP_HI_IGNORED (JUMP_HI_IGNORED)
   ) u_dec (
      .word      (mem_rsp_data),
      .order     (dec_order),
      .is_jump   (dec_is_jump),
      .is_rdback (dec_is_rdback),
      .ba_field  (dec_ba),
      .jt_field  (dec_jt)
   );

   fetch_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .halt          (halt),
      .chan_rst      (chan_rst),
      .next_req      (next_req),
      .next_dchain   (next_dchain),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .dec_is_jump   (dec_is_jump),
      .mem_req_valid (mem_req_valid),
      .ld_start      (ld_start),
      .ld_jump       (ld_jump),
      .inc           (inc),
      .ld_cmd        (ld_cmd),
      .ld_order      (ld_order),
      .dev_busy      (dev_busy),
      .ctl_err       (ctl_err),
      .cmd_loaded    (cmd_loaded),
      .order_pulse   (dev_order_load)
   );

   cmd_addr_reg #(.CAW(CAW)) u_cad (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (chan_rst),
      .ld_start  (ld_start),
      .start_val (start_addr[CAW-1:0]),
      .ld_jump   (ld_jump),
      .jump_val  (dec_jt[CAW-1:0]),
      .inc       (inc),
      .word_addr (mem_req_addr)
   );

   dev_order_regs #(.BAW(BAW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (chan_rst),
      .ld_cmd    (ld_cmd),
      .ld_order  (ld_order),
      .order_in  (dec_order),
      .rdback_in (dec_is_rdback),
      .ba_in     (dec_ba),
      .dev_order (dev_order),
      .byte_addr (byte_addr),
      .backward  (backward)
   );

   // Port-level count of reads in flight, used only by the checks below
   logic [1:0] outst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst <= '0;
      end else begin
         outst <= outst + 2'((mem_req_valid && mem_req_ready) ? 1 : 0)
                         - 2'((mem_rsp_valid && outst != 0) ? 1 : 0);
      end
   end

   // R9: never a second request while one is in flight
   a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (outst != 0 && !mem_rsp_valid) |-> !(mem_req_valid && mem_req_ready));

   // R8: no memory traffic while the control error is raised
   a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_err |-> !mem_req_valid);

   // R7: a jump word leaves every device-side register alone
   a_r7_jump_invisible: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && dec_is_jump && !chan_rst) |=>
         ($stable(dev_order) && $stable(byte_addr) && $stable(backward)
          && !dev_order_load && !cmd_loaded));

   // R4: the order register is only written as part of a command load
   a_r4_load_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      dev_order_load |-> cmd_loaded);

endmodule

// File: tb/sim_chan_cmd_fetch.sv
module sim_chan_cmd_fetch;

   localparam int CAW = 19;
   localparam int BAW = 22;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [31:0]    start_addr = '0;
   logic           halt = 1'b0;
   logic           chan_rst = 1'b0;
   logic           next_req = 1'b0;
   logic           next_dchain = 1'b0;
   logic           mem_req_valid;
   logic           mem_req_ready = 1'b1;
   logic [CAW:0]   mem_req_addr;
   logic           mem_rsp_valid = 1'b0;
   logic [31:0]    mem_rsp_data = '0;
   logic           dev_busy;
   logic [7:0]     dev_order;
   logic           dev_order_load;
   logic [BAW-1:0] byte_addr;
   logic           backward;
   logic           cmd_loaded;
   logic           ctl_err;

   chan_cmd_fetch u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .halt(halt), .chan_rst(chan_rst), .next_req(next_req), .next_dchain(next_dchain),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .dev_busy(dev_busy), .dev_order(dev_order),
      .dev_order_load(dev_order_load), .byte_addr(byte_addr), .backward(backward),
      .cmd_loaded(cmd_loaded), .ctl_err(ctl_err)
   );

   int checks = 0;
   int fails  = 0;
   int n_loaded = 0;
   int lat = 1;
   bit done = 1'b0;

   typedef struct {
      logic [7:0]  ord;
      logic [21:0] ba;
      bit          bk;
      bit          ld;
   } exp_cmd_t;

   logic [31:0] mem [int];
   int unsigned exp_addr[$];
   exp_cmd_t    exp_cmd[$];
   logic [7:0]  cur_ord = '0;
   bit          cur_bk = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // driver side: program memory and queue the expected results
   task automatic put_cmd(input int unsigned waddr, input logic [7:0] ord,
                          input logic [21:0] ba, input bit dch);
      exp_cmd_t e;
      mem[int'(waddr)] = {ord, 2'b00, ba};
      exp_addr.push_back(waddr);
      if (!dch) begin
         cur_ord = ord;
         cur_bk  = (ord == 8'h0C);
      end
      e.ord = cur_ord; e.ba = ba; e.bk = cur_bk; e.ld = !dch;
      exp_cmd.push_back(e);
   endtask

   task automatic put_jump(input int unsigned waddr, input logic [3:0] hi,
                           input logic [18:0] target);
      mem[int'(waddr)] = {hi, 4'b1000, 5'b00000, target};
      exp_addr.push_back(waddr);
   endtask

   task automatic pulse_start(input logic [31:0] a);
      @(negedge clk); start = 1'b1; start_addr = a;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic pulse_next(input bit dch);
      @(negedge clk); next_req = 1'b1; next_dchain = dch;
      @(negedge clk); next_req = 1'b0; next_dchain = 1'b0;
   endtask

   task automatic wait_loaded(input int n);
      while (n_loaded < n) @(negedge clk);
   endtask

   // memory responder: checks each request address against the scoreboard
   initial begin
      int unsigned a;
      @(negedge clk);
      forever begin
         if (rst_n && mem_req_valid && mem_req_ready) begin
            a = 32'(mem_req_addr);
            if (exp_addr.size() == 0) begin
               chk(1'b0, "R3", "unexpected request addr", 64'(a), 64'h0);
            end else begin
               chk(a == exp_addr[0], "R3", "request addr", 64'(a), 64'(exp_addr[0]));
               void'(exp_addr.pop_front());
            end
            @(negedge clk);
            repeat (lat - 1) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
   end

   // monitor: compares each decoded command with the scoreboard
   initial begin
      exp_cmd_t e;
      forever begin
         @(negedge clk);
         if (rst_n && dev_order_load && !cmd_loaded)
            chk(1'b0, "R4", "order load without cmd_loaded", 64'd1, 64'd0);
         if (rst_n && cmd_loaded) begin
            if (exp_cmd.size() == 0) begin
               chk(1'b0, "R9", "unexpected command load", 64'(dev_order), 64'h0);
            end else begin
               e = exp_cmd.pop_front();
               chk(byte_addr == e.ba, "R4", "byte_addr", 64'(byte_addr), 64'(e.ba));
               chk(dev_order == e.ord, e.ld ? "R4" : "R5", "dev_order", 64'(dev_order), 64'(e.ord));
               chk(backward == e.bk, "R6", "backward", 64'(backward), 64'(e.bk));
               chk(dev_order_load == e.ld, "R5", "dev_order_load", 64'(dev_order_load), 64'(e.ld));
            end
            n_loaded++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired", 64'd1, 64'd0);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!dev_busy && !mem_req_valid && !ctl_err, "R1", "busy/req/err", 64'({dev_busy, mem_req_valid, ctl_err}), 64'h0);
      chk(dev_order == 0 && byte_addr == 0 && !backward && !cmd_loaded && !dev_order_load,
          "R1", "registers", 64'({dev_order, byte_addr}), 64'h0);

      // R2/R3/R4 first command from start pointer 0x10
      put_cmd(32'h20, 8'h01, 22'h123456, 1'b0);
      pulse_start(32'h0000_0010);
      chk(dev_busy, "R2", "busy after start", 64'(dev_busy), 64'd1);
      wait_loaded(1);

      // R2 start while busy ignored; R6 read backward order
      pulse_start(32'h0000_0055);
      put_cmd(32'h22, 8'h0C, 22'h000100, 1'b0);
      pulse_next(1'b0);
      wait_loaded(2);

      // R5 data-chained continuation
      put_cmd(32'h24, 8'h05, 22'h3FFFFF, 1'b1);
      pulse_next(1'b1);
      wait_loaded(3);

      // R7 jump inside a data chain, high nibble set
      put_jump(32'h26, 4'hF, 19'h00100);
      put_cmd(32'h200, 8'h02, 22'h000ABC, 1'b1);
      pulse_next(1'b1);
      wait_loaded(4);

      // R6 ordinary order clears backward; R3 pointer continues after jump target
      put_cmd(32'h202, 8'h02, 22'h00ABCD, 1'b0);
      pulse_next(1'b0);
      wait_loaded(5);

      // R8 two jumps in a row
      put_jump(32'h204, 4'h0, 19'h00180);
      put_jump(32'h300, 4'h3, 19'h00000);
      pulse_next(1'b0);
      for (int i = 0; i < 40 && !ctl_err; i++) @(negedge clk);
      chk(ctl_err, "R8", "ctl_err after double jump", 64'(ctl_err), 64'd1);
      chk(!dev_busy, "R8", "busy cleared on error", 64'(dev_busy), 64'd0);
      pulse_start(32'h0000_0010);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!mem_req_valid && !dev_busy, "R8", "quiet in error halt",
             64'({mem_req_valid, dev_busy}), 64'h0);
      end
      chk(exp_addr.size() == 0, "R8", "pending fetches", 64'(exp_addr.size()), 64'd0);

      // R10 channel reset
      @(negedge clk); chan_rst = 1'b1;
      @(negedge clk); chan_rst = 1'b0;
      cur_ord = '0; cur_bk = 1'b0;
      chk(!ctl_err && !dev_busy, "R10", "err/busy after chan_rst", 64'({ctl_err, dev_busy}), 64'h0);
      chk(dev_order == 0 && byte_addr == 0 && !backward, "R10", "registers after chan_rst",
          64'({dev_order, byte_addr, backward}), 64'h0);

      // restart after reset
      put_cmd(32'h60, 8'h0C, 22'h001234, 1'b0);
      pulse_start(32'h0000_0030);
      wait_loaded(6);

      // R9 halt in a loaded state
      @(negedge clk); halt = 1'b1;
      @(negedge clk); halt = 1'b0;
      chk(!dev_busy, "R9", "busy after halt", 64'(dev_busy), 64'd0);

      // R9 halt during an in-flight read, stale response absorbed
      lat = 6;
      mem[32'h80] = {8'h07, 2'b00, 22'h00DEAD};
      exp_addr.push_back(32'h80);
      put_cmd(32'hA0, 8'h03, 22'h000777, 1'b0);
      @(negedge clk); start = 1'b1; start_addr = 32'h40;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 10 && !mem_req_valid; i++) @(negedge clk);
      @(negedge clk); halt = 1'b1;
      @(negedge clk); halt = 1'b0; start = 1'b1; start_addr = 32'h50;
      chk(!dev_busy, "R9", "busy after halt in flight", 64'(dev_busy), 64'd0);
      @(negedge clk); start = 1'b0;
      chk(dev_busy, "R2", "restart while draining", 64'(dev_busy), 64'd1);
      for (int i = 0; i < 2; i++) begin
         chk(!mem_req_valid, "R9", "no request before stale response", 64'(mem_req_valid), 64'd0);
         @(negedge clk);
      end
      chk(!mem_req_valid, "R9", "no request before stale response", 64'(mem_req_valid), 64'd0);
      wait_loaded(7);
      lat = 1;

      repeat (3) @(negedge clk);
      chk(exp_addr.size() == 0 && exp_cmd.size() == 0, "R9", "scoreboard drained",
          64'(exp_addr.size() + exp_cmd.size()), 64'd0);
      report();
   end

endmodule